// File: doc/BRIEF.md
# Bus-Write to JTAG Pin Bridge

This block lets a host on a VME backplane drive a JTAG chain one clock at a time, so that a programmable device and its configuration memory can be loaded even while the main logic of the board is still blank. The block sits on the slave side of the bus. It watches for single-word writes that carry one of four private address modifier codes and hit one fixed address inside the board's slot window. For each such write it copies two data bits onto the TMS and TDI pins, gives one TCK pulse, and only then acknowledges the bus cycle.

The bus strobes and the write line are asynchronous to the local clock, so they pass through a synchronizer before the sequencer acts on them. Address, modifier and data are decoded every cycle. By the time the synchronized strobes show a cycle, the bus protocol keeps those lines stable. A host shifts instructions and data into a device by issuing one write per TCK. It gets no read-back path through this block.

Top module: `vme_jtag_bridge`

## Requirements
- R1: A write is accepted only when the address modifier is 0x19, 0x1A, 0x1D or 0x1E. The standard codes 0x39, 0x3A, 0x3D, 0x3E and all other codes produce no TCK pulse and no acknowledge.
- R2: Address bits 31 to 24 and bits 1 to 0 are ignored. Bits 23 to 19 must equal the slot number, which is the bitwise inverse of the active-low geographic pins. Bits 18 to 2 must equal 0x3FFF, so the low part of the address is 0x0FFFC.
- R3: With geographic pins 11010 (slot 5) the accepted address is 0x28FFFC. With all geographic pins high (no slot number present) it is 0x00FFFC, and 0x28FFFC is then rejected.
- R4: Data bit 0 sets TMS and data bit 1 sets TDI: 00 gives both low, 01 gives TMS high, 10 gives TDI high, 11 gives both high. Data bits 31 to 2 have no effect.
- R5: Each accepted write gives exactly one TCK high pulse of at least HIGH_CYC (default 2) clocks. TMS and TDI take their new values at least one clock before TCK rises and do not change while TCK is high.
- R6: DTACK (active low) is driven only after TCK has returned low, stays driven while the data strobes remain asserted, and is released once both data strobes are high.
- R7: Read cycles to the decode address produce no TCK pulse and no acknowledge.
- R8: After reset and whenever no cycle is being served, TCK is low, TMS is high, TDI is low and DTACK is released.
- R9: From Test-Logic-Reset, five writes of data 1 and one of data 0 bring the TAP to Run-Test/Idle. The fourteen writes 1,1,0,0,0,2,0,2,2,0,2,1,1,0 then load instruction 0x5A (shifted LSB first) and leave the TAP in Run-Test/Idle.
- R10: A data strobe held asserted after the acknowledge produces no further TCK pulse. Each strobe assertion yields at most one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| vme_addr | input | 32 | Bus address lines |
| vme_am | input | 6 | Address modifier code |
| vme_data | input | 32 | Bus data lines |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes, active low |
| vme_write_n | input | 1 | Low for a write cycle |
| vme_ga_n | input | 5 | Geographic address pins, active low |
| jtag_tck | output | 1 | JTAG test clock |
| jtag_tms | output | 1 | JTAG mode select |
| jtag_tdi | output | 1 | JTAG data to the chain |
| vme_dtack_n | output | 1 | Data acknowledge, active low |

## Verification
All four private modifier codes are tried with each of the four two-bit data values. This shows that every code is decoded and that the TMS and TDI bits are not swapped. The mirrored standard codes and an unrelated code are sent to the same address, which separates a decoder that checks all six modifier bits from one that masks bit 5. Addresses with junk in the upper byte, a wrong slot, a wrong low word, and the slot-zero case with all geographic pins high show which address bits take part in the match. Data words with the upper bits set, a held strobe, a read cycle, and a full TAP walk that loads instruction 0x5A check the pulse timing, the one-pulse-per-strobe rule, and the end-to-end JTAG meaning of the writes.

// File: rtl/jtv_pkg.sv
package jtv_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int AM_W    = 6;
    localparam int SLOT_W  = 5;
    localparam int KEY_LSB = 2;
    localparam int KEY_MSB = 18;
    localparam int KEY_W   = KEY_MSB - KEY_LSB + 1;
    localparam int SLOT_LSB = KEY_MSB + 1;
    localparam int SLOT_MSB = SLOT_LSB + SLOT_W - 1;

    // low word 0x0FFFC, seen through address bits 18..2
    localparam logic [KEY_W-1:0] LOW_ADDR_KEY = 17'h03FFF;

    // data bit positions driving the pins
    localparam int TMS_BIT = 0;
    localparam int TDI_BIT = 1;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_SETUP = 3'd1,
        SEQ_HIGH  = 3'd2,
        SEQ_HOLD  = 3'd3,
        SEQ_ACK   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic hit;
        logic tms;
        logic tdi;
    } jtag_req_t;

    typedef struct packed {
        logic as_n;
        logic [1:0] ds_n;
        logic write_n;
    } bus_ctl_t;

    function automatic logic am_is_private(input logic [AM_W-1:0] am);
        logic ok;
        case (am)
            6'h19, 6'h1A, 6'h1D, 6'h1E: ok = 1'b1;
            default:                    ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [SLOT_W-1:0] ga_n);
        return ~ga_n;
    endfunction

endpackage

// File: rtl/jtv_strobe_sync.sv
module jtv_strobe_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= INIT;
                    else     chain[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= INIT;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/jtv_decode.sv
module jtv_decode
    import jtv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [AM_W-1:0]   am,
    input  logic [DATA_W-1:0] data,
    input  logic [SLOT_W-1:0] ga_n,
    output jtag_req_t         req_q
);
    logic      slot_ok;
    logic      key_ok;
    jtag_req_t req_d;

    always_comb begin
        slot_ok   = (addr[SLOT_MSB:SLOT_LSB] == slot_of(ga_n));
        key_ok    = (addr[KEY_MSB:KEY_LSB] == LOW_ADDR_KEY);
        req_d.hit = am_is_private(am) && slot_ok && key_ok;
        req_d.tms = data[TMS_BIT];
        req_d.tdi = data[TDI_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '{hit: 1'b0, tms: 1'b1, tdi: 1'b0};
        else     req_q <= req_d;
    end

    // R1: a registered hit never carries a standard A24 code
    // R1
    std_am_reject_chk: assert property (@(posedge clk) disable iff (rst)
        req_q.hit |-> ($past(am) != 6'h39 && $past(am) != 6'h3A &&
                       $past(am) != 6'h3D && $past(am) != 6'h3E));
endmodule

// File: rtl/jtv_tck_seq.sv
module jtv_tck_seq
    import jtv_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 2,
    parameter int HOLD_CYC  = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cyc_on,
    input  logic      ds_off,
    input  jtag_req_t req,
    output logic      tck,
    output logic      tms,
    output logic      tdi,
    output logic      dtack
);
    localparam int MAX_CYC = (SETUP_CYC > HIGH_CYC) ?
                             ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                             ((HIGH_CYC > HOLD_CYC) ? HIGH_CYC : HOLD_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            tck   <= 1'b0;
            tms   <= 1'b1;
            tdi   <= 1'b0;
            dtack <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (cyc_on && req.hit) begin
                        tms   <= req.tms;
                        tdi   <= req.tdi;
                        cnt   <= CNT_W'(SETUP_CYC - 1);
                        state <= SEQ_SETUP;
                    end
                end
                SEQ_SETUP: begin
                    if (cnt == '0) begin
                        tck   <= 1'b1;
                        cnt   <= CNT_W'(HIGH_CYC - 1);
                        state <= SEQ_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_HIGH: begin
                    if (cnt == '0) begin
                        tck   <= 1'b0;
                        cnt   <= CNT_W'(HOLD_CYC - 1);
                        state <= SEQ_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_HOLD: begin
                    if (cnt == '0) begin
                        dtack <= 1'b1;
                        state <= SEQ_ACK;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_ACK: begin
                    if (ds_off) begin
                        dtack <= 1'b0;
                        tms   <= 1'b1;
                        tdi   <= 1'b0;
                        state <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R5
    pins_hold_tck_chk: assert property (@(posedge clk) disable iff (rst)
        tck |-> ($stable(tms) && $stable(tdi)));

    // R5
    setup_before_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tck) |-> $past(state) == SEQ_SETUP);

    // R6
    ack_after_tck_chk: assert property (@(posedge clk) disable iff (rst)
        dtack |-> !tck);

    // R6
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (dtack && ds_off) |=> !dtack);

    // R8
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE) |-> (!tck && tms && !tdi && !dtack));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_ACK && !ds_off) |=> !tck);
endmodule

// File: rtl/vme_jtag_bridge.sv
module vme_jtag_bridge
    import jtv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 2,
    parameter int HIGH_CYC    = 2,
    parameter int HOLD_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] vme_addr,
    input  logic [AM_W-1:0]   vme_am,
    input  logic [DATA_W-1:0] vme_data,
    input  logic              vme_as_n,
    input  logic [1:0]        vme_ds_n,
    input  logic              vme_write_n,
    input  logic [SLOT_W-1:0] vme_ga_n,
    output logic              jtag_tck,
    output logic              jtag_tms,
    output logic              jtag_tdi,
    output logic              vme_dtack_n
);
    localparam int CTL_W = $bits(bus_ctl_t);

    bus_ctl_t  ctl_raw;
    bus_ctl_t  ctl_s;
    jtag_req_t req;
    logic      cyc_on;
    logic      ds_off;
    logic      dtack;

    assign ctl_raw = '{as_n: vme_as_n, ds_n: vme_ds_n, write_n: vme_write_n};

    jtv_strobe_sync #(
        .W      (CTL_W),
        .STAGES (SYNC_STAGES),
        .INIT   ('1)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ctl_raw),
        .d_sync  (ctl_s)
    );

    jtv_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .addr  (vme_addr),
        .am    (vme_am),
        .data  (vme_data),
        .ga_n  (vme_ga_n),
        .req_q (req)
    );

    assign cyc_on = !ctl_s.as_n && (ctl_s.ds_n != 2'b11) && !ctl_s.write_n;
    assign ds_off = (ctl_s.ds_n == 2'b11);

    jtv_tck_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .cyc_on (cyc_on),
        .ds_off (ds_off),
        .req    (req),
        .tck    (jtag_tck),
        .tms    (jtag_tms),
        .tdi    (jtag_tdi),
        .dtack  (dtack)
    );

    assign vme_dtack_n = !dtack;

    // R7: a TCK rise only happens while a write cycle is being held
    // R7
    tck_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(jtag_tck) |-> (!ctl_s.write_n && !ctl_s.as_n));

    // R6: acknowledge never appears with both data strobes released
    // R6
    ack_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dtack) |-> !ds_off);
endmodule

// File: tb/sim_vme_jtag_bridge.sv
module sim_vme_jtag_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [5:0]  am = '0;
    logic [31:0] data = '0;
    logic        as_n = 1'b1;
    logic [1:0]  ds_n = 2'b11;
    logic        write_n = 1'b1;
    logic [4:0]  ga_n = 5'b11010;
    logic        tck, tms, tdi, dtack_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vme_jtag_bridge u0 (
        .clk(clk), .rst(rst), .vme_addr(addr), .vme_am(am), .vme_data(data),
        .vme_as_n(as_n), .vme_ds_n(ds_n), .vme_write_n(write_n), .vme_ga_n(ga_n),
        .jtag_tck(tck), .jtag_tms(tms), .jtag_tdi(tdi), .vme_dtack_n(dtack_n)
    );

    // ---------------- pin monitor and TAP model ----------------
    logic prev_tck = 1'b0, prev_tms = 1'b1, prev_tdi = 1'b0;
    int   rises = 0, hw = 0, width_viol = 0, setup_viol = 0, hold_viol = 0, ack_viol = 0;
    logic last_tms, last_tdi;
    int   tap = 0;
    logic [7:0] ir_sr = '0, ir = '0;

    function automatic int tap_next(input int s, input logic m);
        case (s)
            0:  return m ? 0 : 1;
            1:  return m ? 2 : 1;
            2:  return m ? 9 : 3;
            3:  return m ? 5 : 4;
            4:  return m ? 5 : 4;
            5:  return m ? 8 : 6;
            6:  return m ? 7 : 6;
            7:  return m ? 8 : 4;
            8:  return m ? 2 : 1;
            9:  return m ? 0 : 10;
            10: return m ? 12 : 11;
            11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            14: return m ? 15 : 11;
            default: return m ? 2 : 1;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (tck && !prev_tck) begin
                rises++;
                last_tms = tms;
                last_tdi = tdi;
                if (tms != prev_tms || tdi != prev_tdi) setup_viol++;
                if (tap == 11) ir_sr = {tdi, ir_sr[7:1]};
                if (tap == 15) ir = ir_sr;
                tap = tap_next(tap, tms);
            end
            if (tck && prev_tck && (tms != prev_tms || tdi != prev_tdi)) hold_viol++;
            if (tck) hw++;
            if (!tck && prev_tck) begin
                if (hw < 2) width_viol++;
                hw = 0;
            end
            if (!dtack_n && tck) ack_viol++;
        end
        prev_tck = tck;
        prev_tms = tms;
        prev_tdi = tdi;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one bus cycle; reports whether DTACK came and how many TCK rises it caused
    task automatic bus_cycle(input logic [31:0] a, input logic [5:0] m, input logic [31:0] d,
                             input logic wr, input int hold, output logic acked,
                             output int pulses);
        int r0;
        acked = 1'b0;
        r0 = rises;
        @(negedge clk);
        addr = a; am = m; data = d; write_n = !wr; as_n = 1'b0;
        @(negedge clk);
        ds_n = 2'b00;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!dtack_n) begin
                acked = 1'b1;
                break;
            end
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (dtack_n) acked = 1'b0;
        end
        ds_n = 2'b11;
        as_n = 1'b1;
        for (int i = 0; i < 8; i++) @(negedge clk);
        write_n = 1'b1;
        pulses = rises - r0;
    endtask

    task automatic good_write(input string req, input logic [31:0] a, input logic [5:0] m,
                              input logic [31:0] d);
        logic ok;
        int   p;
        bus_cycle(a, m, d, 1'b1, 0, ok, p);
        check(req, "ack", {31'd0, ok}, 32'd1);
        check(req, "tck pulses", p, 1);
        check(req, "tms at rise", {31'd0, last_tms}, {31'd0, d[0]});
        check(req, "tdi at rise", {31'd0, last_tdi}, {31'd0, d[1]});
        check("R8", "dtack released", {31'd0, dtack_n}, 32'd1);
    endtask

    task automatic no_response(input string req, input logic [31:0] a, input logic [5:0] m,
                               input logic wr);
        logic ok;
        int   p;
        bus_cycle(a, m, 32'h3, wr, 0, ok, p);
        check(req, "no ack", {31'd0, ok}, 32'd0);
        check(req, "no tck", p, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R8", "tck after reset", {31'd0, tck}, 0);
        check("R8", "tms after reset", {31'd0, tms}, 1);
        check("R8", "tdi after reset", {31'd0, tdi}, 0);
        check("R8", "dtack after reset", {31'd0, dtack_n}, 1);
    endtask

    task automatic t_private_codes();
        logic [5:0] codes [4] = '{6'h19, 6'h1A, 6'h1D, 6'h1E};
        for (int k = 0; k < 4; k++)
            for (int v = 0; v < 4; v++)
                good_write("R1 R4", 32'h0028FFFC, codes[k], 32'(v));
    endtask

    task automatic t_standard_codes();
        no_response("R1", 32'h0028FFFC, 6'h39, 1'b1);
        no_response("R1", 32'h0028FFFC, 6'h3A, 1'b1);
        no_response("R1", 32'h0028FFFC, 6'h3D, 1'b1);
        no_response("R1", 32'h0028FFFC, 6'h3E, 1'b1);
        no_response("R1", 32'h0028FFFC, 6'h09, 1'b1);
    endtask

    task automatic t_address();
        good_write("R2", 32'hA528FFFC, 6'h19, 32'h1);
        good_write("R2", 32'h0028FFFF, 6'h1A, 32'h2);
        no_response("R2", 32'h0030FFFC, 6'h19, 1'b1);
        no_response("R2", 32'h0028FFF8, 6'h19, 1'b1);
        no_response("R2", 32'h002CFFFC, 6'h19, 1'b1);
        good_write("R3", 32'h0028FFFC, 6'h1D, 32'h3);
        ga_n = 5'b11111;
        good_write("R3", 32'h0000FFFC, 6'h19, 32'h1);
        no_response("R3", 32'h0028FFFC, 6'h19, 1'b1);
        ga_n = 5'b11010;
    endtask

    task automatic t_upper_data();
        good_write("R4", 32'h0028FFFC, 6'h19, 32'hFFFFFFFC);
        good_write("R4", 32'h0028FFFC, 6'h19, 32'hABCDEF01);
        good_write("R4", 32'h0028FFFC, 6'h1E, 32'h5555_5556);
    endtask

    task automatic t_read();
        no_response("R7", 32'h0028FFFC, 6'h19, 1'b0);
        no_response("R7", 32'h0028FFFC, 6'h1A, 1'b0);
    endtask

    task automatic t_hold_strobe();
        logic ok;
        int   p;
        bus_cycle(32'h0028FFFC, 6'h19, 32'h2, 1'b1, 30, ok, p);
        check("R6", "ack held with strobe", {31'd0, ok}, 1);
        check("R10", "one pulse on held strobe", p, 1);
        check("R6", "ack released after strobe", {31'd0, dtack_n}, 1);
        check("R8", "tms idle after write", {31'd0, tms}, 1);
        check("R8", "tdi idle after write", {31'd0, tdi}, 0);
    endtask

    task automatic t_tap_sequence();
        int seq [14] = '{1, 1, 0, 0, 0, 2, 0, 2, 2, 0, 2, 1, 1, 0};
        logic ok;
        int   p;
        for (int i = 0; i < 5; i++) bus_cycle(32'h0028FFFC, 6'h19, 32'h1, 1'b1, 0, ok, p);
        bus_cycle(32'h0028FFFC, 6'h19, 32'h0, 1'b1, 0, ok, p);
        check("R9", "tap at run-test/idle", tap, 1);
        for (int i = 0; i < 14; i++)
            bus_cycle(32'h0028FFFC, 6'h1A, 32'(seq[i]), 1'b1, 0, ok, p);
        check("R9", "instruction loaded", {24'd0, ir}, 32'h5A);
        check("R9", "tap back at run-test/idle", tap, 1);
    endtask

    // ---------------- main ----------------
    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_private_codes();
        t_standard_codes();
        t_address();
        t_upper_data();
        t_read();
        t_hold_strobe();
        t_tap_sequence();
        check("R5", "tck high width", width_viol, 0);
        check("R5", "pins set before rise", setup_viol, 0);
        check("R5", "pins stable while high", hold_viol, 0);
        check("R6", "ack while tck high", ack_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule